// File: doc/BRIEF.md
# Indexed Operand Address Generator

This block turns the indexed-mode postbyte of a 16-bit microcontroller into an effective operand address. The postbyte selects one of several mode families: a short signed constant added to a base register, auto increment or decrement of an index register, a 9-bit or 16-bit constant offset, an accumulator offset, and two indirect forms. In the indirect forms the computed sum points at a 16-bit pointer in memory, and that pointer becomes the operand address.

An instruction sequencer pulses `start` with the postbyte, the extension bytes that follow it, and a snapshot of the X, Y, SP, PC, A and B registers. For direct modes the result appears one cycle later with `done`. For indirect modes the block raises `ptr_req` with the pointer's address and holds it until memory answers with `ptr_ack` and `ptr_data`. `done` follows one cycle after that. With the result the block also returns the updated index register value for auto-modify modes, and a count of the extra cycles the mode costs.

Top module: `idx_addr_gen`

## Requirements
- R1: With postbyte bit 5 at 0, the address is the base register plus bits 4:0 read as a signed 5-bit constant. Bits 7:6 pick the base register.
- R2: A 2-bit register code of 0 selects X, 1 selects Y, 2 selects SP and 3 selects PC. The code comes from bits 7:6 in the short-constant and auto-modify modes, and from bits 4:3 when bits 7:5 are all 1.
- R3: With bit 5 at 1 and bits 7:6 not both 1, the mode is auto-modify. The step is taken from bits 3:0: codes 0..7 step by +1..+8, and codes 8..15 step by -8..-1. With `done`, `wb_en` is 1, `wb_sel` carries the register code from bits 7:6, and `wb_val` is the old register value plus the step. In every other mode `wb_en` stays 0.
- R4: In auto-modify mode, bit 4 at 0 makes the updated register value the address (pre-modify). Bit 4 at 1 makes the original value the address (post-modify).
- R5: With bits 7:5 all 1 and bits 2:0 equal to 000 or 001, the offset is 9 bits wide. Its low 8 bits are `ext0`, its sign is postbyte bit 0, and no extra cycle is added.
- R6: With bits 7:5 all 1 and bits 2:0 equal to 010, the offset is the 16-bit value {`ext0`,`ext1`} and `extra_cyc` is 1.
- R7: With bits 7:5 all 1, bit 2 at 1 and bits 1:0 at 00, 01 or 10, the register is offset by A, B or D. A and B are zero-extended, D is {A,B}, and `extra_cyc` is 0.
- R8: Two modes are indirect: bits 2:0 equal to 011 (the register plus {`ext0`,`ext1`}) and bits 2:0 equal to 111 (the register plus D), both with bits 7:5 all 1. In these modes `ptr_req` is raised with `ptr_addr` set to the sum and held steady until `ptr_ack`. The address then becomes `ptr_data`, `ind_read` is 1 and `extra_cyc` is 1.
- R9: For a direct mode, `done` is 1 exactly one cycle after `start`. For an indirect mode, it is 1 exactly one cycle after `ptr_ack`. It lasts one cycle unless a new start follows. A `start` that arrives while a pointer fetch is pending is ignored.
- R10: All address sums wrap modulo 2^16.
- R11: During and right after reset, `done`, `wb_en` and `ptr_req` are 0, and reset cancels a pending pointer fetch.
- R12: The short-constant, auto-modify and 9-bit modes report `extra_cyc` of 0 and `ind_read` of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin decoding the presented postbyte |
| postbyte | input | 8 | Indexed-mode postbyte |
| ext0 | input | 8 | First extension byte |
| ext1 | input | 8 | Second extension byte |
| reg_x | input | 16 | X index register |
| reg_y | input | 16 | Y index register |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter value used as base |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| ptr_ack | input | 1 | Memory returns the indirect pointer |
| ptr_data | input | 16 | Indirect pointer value |
| done | output | 1 | Result valid pulse |
| eff_addr | output | 16 | Effective operand address |
| wb_en | output | 1 | Write back an auto-modified register |
| wb_sel | output | 2 | Register code to write back |
| wb_val | output | 16 | Updated register value |
| ind_read | output | 1 | The mode needed an indirect pointer read |
| extra_cyc | output | 2 | Extra cycles caused by the mode |
| ptr_req | output | 1 | Indirect pointer read request |
| ptr_addr | output | 16 | Address of the indirect pointer |

## Verification
The checker assumes that memory raises `ptr_ack` only while `ptr_req` is high and that `ptr_data` is valid in the same cycle as `ptr_ack`. The bench's memory model answers only after it has seen the request, and it varies the wait from zero to several cycles. It drops `ptr_ack` as soon as the answer has been accepted. Register and extension inputs change only in the cycle of a `start`, which matches the assumption that the block works from its own captured copy.

// File: rtl/idx_pkg.sv
// Shared types for the indexed address generator.
// Assumes a byte-wide postbyte; widths of data paths are set by the modules.
package idx_pkg;

    typedef enum logic [2:0] {
        M_K5     = 3'd0,
        M_AUTO   = 3'd1,
        M_K9     = 3'd2,
        M_K16    = 3'd3,
        M_IND16  = 3'd4,
        M_ACC    = 3'd5,
        M_ACCIND = 3'd6
    } idx_mode_e;

    typedef enum logic [1:0] {
        R_X  = 2'd0,
        R_Y  = 2'd1,
        R_SP = 2'd2,
        R_PC = 2'd3
    } idx_reg_e;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_FETCH = 1'b1
    } idx_state_e;

endpackage

// File: rtl/idx_decode.sv
// Postbyte decoder: classifies the postbyte into a mode family, picks the
// base register and accumulator, and reports the extra cycle cost.
// Assumes an 8-bit postbyte; purely combinational.
module idx_decode
    import idx_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic [7:0]    pb,
    output idx_mode_e     mode,
    output idx_reg_e      base,
    output logic          post,
    output logic [1:0]    acc_sel,
    output logic [CW-1:0] xcyc
);

    // Priority decode of the mode families.
    always_comb begin
        mode    = M_K5;
        base    = idx_reg_e'(pb[7:6]);
        post    = pb[4];
        acc_sel = pb[1:0];
        xcyc    = '0;
        if (!pb[5]) begin
            mode = M_K5;
        end else if (pb[7:6] != 2'b11) begin
            mode = M_AUTO;
        end else begin
            base = idx_reg_e'(pb[4:3]);
            if (pb[2:0] == 3'b011) begin
                mode = M_IND16;
                xcyc = CW'(1);
            end else if (!pb[2]) begin
                if (pb[1]) begin
                    mode = M_K16;
                    xcyc = CW'(1);
                end else begin
                    mode = M_K9;
                end
            end else if (pb[1:0] == 2'b11) begin
                mode = M_ACCIND;
                xcyc = CW'(1);
            end else begin
                mode = M_ACC;
            end
        end
    end

endmodule

// File: rtl/idx_offset.sv
// Offset builder: forms the AW-bit signed or unsigned offset that a mode
// adds to its base register. Assumes AW is twice the byte width BW.
module idx_offset
    import idx_pkg::*;
#(
    parameter int BW = 8
) (
    input  idx_mode_e       mode,
    input  logic [1:0]      acc_sel,
    input  logic [4:0]      pb_lo,
    input  logic [BW-1:0]   ext0,
    input  logic [BW-1:0]   ext1,
    input  logic [BW-1:0]   acc_a,
    input  logic [BW-1:0]   acc_b,
    output logic [2*BW-1:0] off
);

    localparam int AW = 2 * BW;

    logic [AW-1:0] step;

    // Auto-modify step: 0..7 -> +1..+8, 8..15 -> -8..-1.
    always_comb begin
        if (pb_lo[3]) step = {{(AW-4){1'b1}}, pb_lo[3:0]};
        else          step = {{(AW-4){1'b0}}, pb_lo[3:0]} + AW'(1);
    end

    // Offset selection by mode family.
    always_comb begin
        case (mode)
            M_K5:    off = {{(AW-5){pb_lo[4]}}, pb_lo};
            M_AUTO:  off = step;
            M_K9:    off = {{(AW-BW){pb_lo[0]}}, ext0};
            M_K16,
            M_IND16: off = {ext0, ext1};
            M_ACC,
            M_ACCIND: begin
                case (acc_sel)
                    2'd0:    off = {{(AW-BW){1'b0}}, acc_a};
                    2'd1:    off = {{(AW-BW){1'b0}}, acc_b};
                    default: off = {acc_a, acc_b};
                endcase
            end
            default: off = '0;
        endcase
    end

endmodule

// File: rtl/idx_adder.sv
// Base select and address adder: picks the base register, adds the offset
// modulo 2^AW, and chooses between the sum and the base for post-modify.
module idx_adder
    import idx_pkg::*;
#(
    parameter int AW = 16
) (
    input  idx_mode_e     mode,
    input  idx_reg_e      base,
    input  logic          post,
    input  logic [AW-1:0] reg_x,
    input  logic [AW-1:0] reg_y,
    input  logic [AW-1:0] reg_sp,
    input  logic [AW-1:0] reg_pc,
    input  logic [AW-1:0] off,
    output logic [AW-1:0] sum,
    output logic [AW-1:0] ea_direct
);

    logic [AW-1:0] base_val;

    // Base register multiplexer.
    always_comb begin
        case (base)
            R_X:     base_val = reg_x;
            R_Y:     base_val = reg_y;
            R_SP:    base_val = reg_sp;
            default: base_val = reg_pc;
        endcase
    end

    // Wrapping sum and pre/post selection.
    always_comb begin
        sum       = base_val + off;
        ea_direct = (mode == M_AUTO && post) ? base_val : sum;
    end

endmodule

// File: rtl/idx_addr_gen.sv
// Indexed operand address generator top. Captures a postbyte on start,
// returns the address one cycle later for direct modes, or after a pointer
// fetch handshake for indirect modes. Assumes ptr_ack only while ptr_req.
module idx_addr_gen
    import idx_pkg::*;
#(
    parameter int BW = 8,
    parameter int CW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [7:0]          postbyte,
    input  logic [BW-1:0]       ext0,
    input  logic [BW-1:0]       ext1,
    input  logic [2*BW-1:0]     reg_x,
    input  logic [2*BW-1:0]     reg_y,
    input  logic [2*BW-1:0]     reg_sp,
    input  logic [2*BW-1:0]     reg_pc,
    input  logic [BW-1:0]       acc_a,
    input  logic [BW-1:0]       acc_b,
    input  logic                ptr_ack,
    input  logic [2*BW-1:0]     ptr_data,
    output logic                done,
    output logic [2*BW-1:0]     eff_addr,
    output logic                wb_en,
    output logic [1:0]          wb_sel,
    output logic [2*BW-1:0]     wb_val,
    output logic                ind_read,
    output logic [CW-1:0]       extra_cyc,
    output logic                ptr_req,
    output logic [2*BW-1:0]     ptr_addr
);

    localparam int AW = 2 * BW;

    idx_mode_e     mode;
    idx_reg_e      base;
    logic          post;
    logic [1:0]    acc_sel;
    logic [CW-1:0] xcyc;
    logic [AW-1:0] off;
    logic [AW-1:0] sum;
    logic [AW-1:0] ea_direct;
    logic          is_ind;
    idx_state_e    st;

    idx_decode #(.CW(CW)) dec_i (
        .pb(postbyte), .mode(mode), .base(base), .post(post),
        .acc_sel(acc_sel), .xcyc(xcyc)
    );

    idx_offset #(.BW(BW)) off_i (
        .mode(mode), .acc_sel(acc_sel), .pb_lo(postbyte[4:0]),
        .ext0(ext0), .ext1(ext1), .acc_a(acc_a), .acc_b(acc_b), .off(off)
    );

    idx_adder #(.AW(AW)) add_i (
        .mode(mode), .base(base), .post(post),
        .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
        .off(off), .sum(sum), .ea_direct(ea_direct)
    );

    // Indirect mode detect.
    always_comb is_ind = (mode == M_IND16) || (mode == M_ACCIND);

    // Pointer request follows the fetch state.
    always_comb ptr_req = (st == S_FETCH);

    // Capture, fetch handshake and result pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            done      <= 1'b0;
            eff_addr  <= '0;
            wb_en     <= 1'b0;
            wb_sel    <= 2'd0;
            wb_val    <= '0;
            ind_read  <= 1'b0;
            extra_cyc <= '0;
            ptr_addr  <= '0;
        end else begin
            done  <= 1'b0;
            wb_en <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start) begin
                        ind_read  <= is_ind;
                        extra_cyc <= xcyc;
                        wb_sel    <= base;
                        wb_val    <= sum;
                        if (is_ind) begin
                            ptr_addr <= sum;
                            st       <= S_FETCH;
                        end else begin
                            eff_addr <= ea_direct;
                            wb_en    <= (mode == M_AUTO);
                            done     <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (ptr_ack) begin
                        eff_addr <= ptr_data;
                        done     <= 1'b1;
                        st       <= S_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/idx_addr_gen_chk.sv
// Protocol checker for idx_addr_gen, attached by bind.
// Assumes memory asserts ptr_ack only while ptr_req is high.
module idx_addr_gen_chk #(
    parameter int BW = 8,
    parameter int CW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            ptr_ack,
    input logic [2*BW-1:0] ptr_data,
    input logic            done,
    input logic [2*BW-1:0] eff_addr,
    input logic            wb_en,
    input logic            ind_read,
    input logic [CW-1:0]   extra_cyc,
    input logic            ptr_req,
    input logic [2*BW-1:0] ptr_addr
);

    // R8
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_req && !ptr_ack |=> ptr_req && $stable(ptr_addr));

    // R8
    ptr_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_req && ptr_ack |=> done && !ptr_req && eff_addr == $past(ptr_data));

    // R8
    ind_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && ind_read |-> extra_cyc == CW'(1) && !wb_en);

    // R3
    wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // R9
    direct_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !ptr_req |=> done || ptr_req);

    // R11
    fetch_needs_ind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_req |-> ind_read && !done);

endmodule

bind idx_addr_gen idx_addr_gen_chk #(.BW(BW), .CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ptr_ack(ptr_ack),
    .ptr_data(ptr_data), .done(done), .eff_addr(eff_addr), .wb_en(wb_en),
    .ind_read(ind_read), .extra_cyc(extra_cyc), .ptr_req(ptr_req),
    .ptr_addr(ptr_addr)
);

// File: tb/idx_addr_gen_tb_top.sv
module idx_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  postbyte = '0;
    logic [7:0]  ext0 = '0;
    logic [7:0]  ext1 = '0;
    logic [15:0] reg_x  = 16'h1000;
    logic [15:0] reg_y  = 16'h2000;
    logic [15:0] reg_sp = 16'h3FF0;
    logic [15:0] reg_pc = 16'hC010;
    logic [7:0]  acc_a = 8'h85;
    logic [7:0]  acc_b = 8'h3C;
    logic        ptr_ack = 1'b0;
    logic [15:0] ptr_data = '0;
    logic        done;
    logic [15:0] eff_addr;
    logic        wb_en;
    logic [1:0]  wb_sel;
    logic [15:0] wb_val;
    logic        ind_read;
    logic [1:0]  extra_cyc;
    logic        ptr_req;
    logic [15:0] ptr_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    idx_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
        .ext0(ext0), .ext1(ext1), .reg_x(reg_x), .reg_y(reg_y),
        .reg_sp(reg_sp), .reg_pc(reg_pc), .acc_a(acc_a), .acc_b(acc_b),
        .ptr_ack(ptr_ack), .ptr_data(ptr_data), .done(done),
        .eff_addr(eff_addr), .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val),
        .ind_read(ind_read), .extra_cyc(extra_cyc), .ptr_req(ptr_req),
        .ptr_addr(ptr_addr)
    );

    // {postbyte, ext0, ext1, addr, wb_en, wb_val, extra}
    localparam int NV = 16;
    localparam logic [58:0] VEC [NV] = '{
        {8'h05, 8'h00, 8'h00, 16'h1005, 1'b0, 16'h0000, 2'd0}, // R1 X+5
        {8'h5F, 8'h00, 8'h00, 16'h1FFF, 1'b0, 16'h0000, 2'd0}, // R1 Y-1
        {8'h90, 8'h00, 8'h00, 16'h3FE0, 1'b0, 16'h0000, 2'd0}, // R2 SP-16
        {8'hCF, 8'h00, 8'h00, 16'hC01F, 1'b0, 16'h0000, 2'd0}, // R2 PC+15
        {8'h20, 8'h00, 8'h00, 16'h1001, 1'b1, 16'h1001, 2'd0}, // R4 pre +1
        {8'h3F, 8'h00, 8'h00, 16'h1000, 1'b1, 16'h0FFF, 2'd0}, // R4 post -1
        {8'h67, 8'h00, 8'h00, 16'h2008, 1'b1, 16'h2008, 2'd0}, // R3 pre +8
        {8'hB8, 8'h00, 8'h00, 16'h3FF0, 1'b1, 16'h3FE8, 2'd0}, // R3 post -8
        {8'hE0, 8'h7F, 8'h00, 16'h107F, 1'b0, 16'h0000, 2'd0}, // R5 +0x7F
        {8'hE9, 8'h10, 8'h00, 16'h1F10, 1'b0, 16'h0000, 2'd0}, // R5 -0xF0
        {8'hF2, 8'h12, 8'h34, 16'h5224, 1'b0, 16'h0000, 2'd1}, // R6 SP
        {8'hFA, 8'h40, 8'h00, 16'h0010, 1'b0, 16'h0000, 2'd1}, // R10 wrap
        {8'hE4, 8'h00, 8'h00, 16'h1085, 1'b0, 16'h0000, 2'd0}, // R7 A
        {8'hED, 8'h00, 8'h00, 16'h203C, 1'b0, 16'h0000, 2'd0}, // R7 B
        {8'hF6, 8'h00, 8'h00, 16'hC52C, 1'b0, 16'h0000, 2'd0}, // R7 D
        {8'hFE, 8'h00, 8'h00, 16'h454C, 1'b0, 16'h0000, 2'd0}  // R10 PC+D
    };

    function automatic string tag_of(input logic [7:0] pb);
        if (!pb[5])                 return "R1";
        if (pb[7:6] != 2'b11)       return "R3";
        if (pb[2:0] == 3'b010)      return "R6";
        if (!pb[2])                 return "R5";
        return "R7";
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] pb, input logic [7:0] e0, input logic [7:0] e1);
        @(negedge clk);
        postbyte = pb; ext0 = e0; ext1 = e1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!done && !wb_en && !ptr_req, "R11", "outputs in reset",
              {done, wb_en, ptr_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !wb_en && !ptr_req, "R11", "outputs after reset",
              {done, wb_en, ptr_req}, 0);

        // Vector table, direct modes
        for (int i = 0; i < NV; i++) begin
            logic [58:0] v;
            string t;
            v = VEC[i];
            t = tag_of(v[58:51]);
            issue(v[58:51], v[50:43], v[42:35]);
            check(done, "R9", "done one cycle after start", done, 1);
            check(eff_addr == v[34:19], t, "address", eff_addr, v[34:19]);
            check(wb_en == v[18], "R3", "wb_en", wb_en, v[18]);
            if (v[18]) begin
                check(wb_val == v[17:2], "R3", "wb_val", wb_val, v[17:2]);
                check(wb_sel == v[58:57], "R3", "wb_sel", wb_sel, v[58:57]);
            end
            check(extra_cyc == v[1:0], "R12", "extra cycles", extra_cyc, v[1:0]);
            check(!ind_read, "R12", "ind_read on direct mode", ind_read, 0);
            @(negedge clk);
            check(!done && !wb_en, "R9", "done single pulse", {done, wb_en}, 0);
        end

        // R8 indirect 16-bit offset: X + 0x0100 -> pointer, late ack
        issue(8'hE3, 8'h01, 8'h00);
        check(ptr_req && ptr_addr == 16'h1100, "R8", "pointer request addr",
              {ptr_req, ptr_addr}, {1'b1, 16'h1100});
        check(!done, "R9", "no done while fetching", done, 0);
        // R9 start during fetch is ignored
        @(negedge clk);
        postbyte = 8'h05; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(ptr_req && ptr_addr == 16'h1100 && !done, "R9", "start ignored while busy",
              {ptr_req, done, ptr_addr}, {2'b10, 16'h1100});
        ptr_data = 16'hBEEF; ptr_ack = 1'b1;
        @(negedge clk);
        ptr_ack = 1'b0;
        check(done && eff_addr == 16'hBEEF, "R8", "address from pointer",
              eff_addr, 16'hBEEF);
        check(ind_read && extra_cyc == 2'd1 && !wb_en, "R8", "indirect flags",
              {ind_read, wb_en, extra_cyc}, {2'b10, 2'd1});
        check(!ptr_req, "R8", "request dropped", ptr_req, 0);
        @(negedge clk);
        check(!done, "R9", "ignored start gives no done", done, 0);

        // R8 accumulator D indirect with wrap (R10), immediate ack
        @(negedge clk);
        postbyte = 8'hFF; ext0 = 8'h00; ext1 = 8'h00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(ptr_req && ptr_addr == 16'h454C, "R10", "D indirect wrapped sum",
              ptr_addr, 16'h454C);
        ptr_data = 16'h5A5A; ptr_ack = 1'b1;
        @(negedge clk);
        ptr_ack = 1'b0;
        check(done && eff_addr == 16'h5A5A && extra_cyc == 2'd1, "R8",
              "D indirect result", eff_addr, 16'h5A5A);

        // R11 reset cancels a pending fetch
        issue(8'hE3, 8'h00, 8'h10);
        check(ptr_req, "R8", "fetch pending", ptr_req, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!ptr_req && !done, "R11", "reset cancels fetch", {ptr_req, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        issue(8'h05, 8'h00, 8'h00);
        check(done && eff_addr == 16'h1005, "R11", "direct op after reset",
              eff_addr, 16'h1005);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule